// File: doc/BRIEF.md
# Mode-Controlled Multiplexed Port Interface

This block owns four 8-bit pin groups, called A, B, E and K. Depending on an operating mode, it hands them either to general-purpose I/O or to an external bus. On that bus, address and data share the same pins.

The mode is taken from three strap pins while reset is held, and it stays fixed until the next reset. Software uses a small internal register bus to set the following:

- per-port output values and directions;
- a pull-up byte and a drive-strength byte;
- a bus-control byte and an interrupt-control byte;
- a port E assignment byte;
- a mode byte that carries the internal-visibility request.

An external bus cycle starts when a request is accepted. It then runs through an address phase and a data phase, one clock each.

- In wide modes, A and B together carry a 16-bit address and then 16-bit data.
- In narrow modes, A and B carry the address, and only A is reused for 8-bit data while B keeps the low address byte.
- Port E supplies the read/write and address-strobe signals.
- Port K stays general-purpose in every mode.

Top module: `xbus_top`

## Requirements
- R1: On every clock while `rstN` is low, `modePins` is copied into the mode latch. After release, the latch holds, whatever the pins do. The latch reads back in bits [7:5] of offset 0x0B. Mode codes are: 000 special single-chip, 001 emulation narrow, 010 special test, 011 emulation wide, 100 normal single-chip, 101 normal narrow, 110 special peripheral, 111 normal wide.
- R2: The mapped offsets are 0x00/0x01 A/B data, 0x02/0x03 A/B direction, 0x08/0x09 E data/direction, 0x0A E assignment, 0x0B mode, 0x0C pull-up, 0x0D drive, 0x0E bus control, 0x1E IRQ control, 0x32/0x33 K data/direction. All of them reset to zero and read back what was written. `pullCfg` and `driveCfg` show the pull-up and drive bytes.
- R3: Offsets 0x04–0x07, 0x0F and every unmapped offset read as zero, and writes to them change no register.
- R4: A port operating as GPIO drives its data register on `padOut*` and its direction register on `padOe*`. A data-register read returns the register bit where the direction bit is 1 and the pin level where it is 0. K is GPIO in all modes. A, B and E are GPIO in modes 000, 100 and 110.
- R5: Wide modes are 011, 111 and 010. In these modes a request starts a cycle on the next clock, as follows:
  - Address phase: A drives address[15:8] and B drives address[7:0], with both fully enabled.
  - Data phase: A and B drive write data [15:8] and [7:0] on a write, or are released on a read.
  - The clock after the data phase pulses `busDone`, and on a read `busRdata` then holds {A,B}.
  - Between cycles, A and B are released.
- R6: Narrow modes are 001 and 101. The address phase is the same as in wide modes. In the data phase, A carries write data [7:0] (or is released on a read), while B keeps driving address[7:0]. A read returns {8'h00, A}.
- R7: In wide and narrow modes, E bit 2 is driven low during write phases and high otherwise, and E bit 3 is driven high only in the address phase. The other E bits stay GPIO.
- R8: `visOn` equals mode-register bit 3 when the mode is 011, 111, 010 or 001, and is 0 in every other mode.
- R9: In normal modes (100, 101, 111), mode bit 3 and the bus-control byte take only the first write after reset. In all other modes they take every write.
- R10: While `stop` is high, register writes are dropped, reads return zero and the bus-cycle phases freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; mode pins sampled while low |
| stop | input | 1 | Freezes all activity while high |
| modePins | input | 3 | Mode strap pins {C,B,A} |
| regAddr | input | 6 | Register offset |
| regWdata | input | 8 | Register write data |
| regWe | input | 1 | Register write enable |
| regRe | input | 1 | Register read enable |
| regRdata | output | 8 | Register read data (zero when not reading) |
| busReq | input | 1 | Request an external bus cycle |
| busWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| busAddr | input | 16 | External cycle address |
| busWdata | input | 16 | External write data |
| busRdata | output | 16 | Data captured in the data phase |
| busDone | output | 1 | One-clock pulse after the data phase |
| busAddrPhase | output | 1 | Address phase active |
| busDataPhase | output | 1 | Data phase active |
| padInA | input | 8 | Pin levels, port A |
| padInB | input | 8 | Pin levels, port B |
| padInE | input | 8 | Pin levels, port E |
| padInK | input | 8 | Pin levels, port K |
| padOutA | output | 8 | Output values, port A |
| padOutB | output | 8 | Output values, port B |
| padOutE | output | 8 | Output values, port E |
| padOutK | output | 8 | Output values, port K |
| padOeA | output | 8 | Output enables, port A |
| padOeB | output | 8 | Output enables, port B |
| padOeE | output | 8 | Output enables, port E |
| padOeK | output | 8 | Output enables, port K |
| pullCfg | output | 8 | Pull-up configuration byte |
| driveCfg | output | 8 | Reduced-drive configuration byte |
| visOn | output | 1 | Internal visibility in effect |

## Verification
A wrong mode latch is the most damaging internal fault. It shows at once as the wrong read-back in bits [7:5] of the mode byte, and on the first bus request as ports A and B remaining GPIO or splitting address and data the wrong way. A lock flag stuck in either state shows on the second write to the bus-control byte. A phase machine that skips or repeats a phase is visible within three clocks of a request: through the phase outputs, the output enables on A and B, the E strobes, and a late or missing `busDone`.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int PORT_W = 8;
  localparam int ADDR_W = 6;
  localparam int MODE_W = 3;
  localparam int NREG   = 14;

  typedef enum logic [3:0] {
    R_PA, R_PB, R_DA, R_DB, R_PE, R_DE, R_PEASN, R_MODE,
    R_PULL, R_DRV, R_BCTL, R_IRQ, R_PK, R_DK, R_NONE
  } regId_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NREG-1:0] wrSel;
    regId_t          rdSel;
    logic            rdEn;
    logic            busStart;
    logic            addrPh;
    logic            dataPh;
    logic            isWrite;
    logic            wideBus;
    logic            narrowBus;
    logic            visAllowed;
    logic            hold;
  } strobe_t;

  function automatic regId_t decodeOffset(input logic [ADDR_W-1:0] a);
    case (a)
      6'h00: decodeOffset = R_PA;
      6'h01: decodeOffset = R_PB;
      6'h02: decodeOffset = R_DA;
      6'h03: decodeOffset = R_DB;
      6'h08: decodeOffset = R_PE;
      6'h09: decodeOffset = R_DE;
      6'h0A: decodeOffset = R_PEASN;
      6'h0B: decodeOffset = R_MODE;
      6'h0C: decodeOffset = R_PULL;
      6'h0D: decodeOffset = R_DRV;
      6'h0E: decodeOffset = R_BCTL;
      6'h1E: decodeOffset = R_IRQ;
      6'h32: decodeOffset = R_PK;
      6'h33: decodeOffset = R_DK;
      default: decodeOffset = R_NONE;
    endcase
  endfunction

endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stop,
  input  logic [MODE_W-1:0] modePins,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              regRe,
  input  logic              busReq,
  input  logic              busWrite,
  output logic [MODE_W-1:0] modeNow,
  output strobe_t           stb
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} phase_t;

  logic [MODE_W-1:0] modeLat;
  phase_t            phase;
  logic              wrLat;
  logic              modeLock;
  logic              bctlLock;
  logic              isWide;
  logic              isNarrow;
  logic              isNormal;
  regId_t            rid;
  logic [NREG-1:0]   wrRaw;

  // mode straps follow the pins only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) modeLat <= modePins;
  end

  assign modeNow  = modeLat;
  assign isWide   = (modeLat == 3'b011) || (modeLat == 3'b111) || (modeLat == 3'b010);
  assign isNarrow = (modeLat == 3'b001) || (modeLat == 3'b101);
  assign isNormal = (modeLat == 3'b100) || (modeLat == 3'b101) || (modeLat == 3'b111);
  assign rid      = decodeOffset(regAddr);

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      wrRaw[i] = regWe && !stop && (4'(rid) == 4'(i));
    end
  end

  always_comb begin
    stb.wrSel = wrRaw;
    if (isNormal && modeLock) stb.wrSel[R_MODE] = 1'b0;
    if (isNormal && bctlLock) stb.wrSel[R_BCTL] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeLock <= 1'b0;
      bctlLock <= 1'b0;
    end else begin
      if (wrRaw[R_MODE] && isNormal) modeLock <= 1'b1;
      if (wrRaw[R_BCTL] && isNormal) bctlLock <= 1'b1;
    end
  end

  assign stb.busStart = (phase == ST_IDLE) && busReq && (isWide || isNarrow) && !stop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      wrLat <= 1'b0;
    end else if (!stop) begin
      case (phase)
        ST_IDLE: if (stb.busStart) begin
          phase <= ST_ADDR;
          wrLat <= busWrite;
        end
        ST_ADDR: phase <= ST_DATA;
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assign stb.rdSel      = rid;
  assign stb.rdEn       = regRe && !stop;
  assign stb.addrPh     = (phase == ST_ADDR);
  assign stb.dataPh     = (phase == ST_DATA);
  assign stb.isWrite    = wrLat;
  assign stb.wideBus    = isWide;
  assign stb.narrowBus  = isNarrow;
  assign stb.visAllowed = isWide || (modeLat == 3'b001);
  assign stb.hold       = stop;

endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath
  import xbus_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [MODE_W-1:0] modeNow,
  input  logic [W-1:0]      regWdata,
  input  logic [2*W-1:0]    busAddr,
  input  logic [2*W-1:0]    busWdata,
  input  logic [W-1:0]      padInA,
  input  logic [W-1:0]      padInB,
  input  logic [W-1:0]      padInE,
  input  logic [W-1:0]      padInK,
  output logic [W-1:0]      regRdata,
  output logic [2*W-1:0]    busRdata,
  output logic              busDone,
  output logic [W-1:0]      padOutA,
  output logic [W-1:0]      padOutB,
  output logic [W-1:0]      padOutE,
  output logic [W-1:0]      padOutK,
  output logic [W-1:0]      padOeA,
  output logic [W-1:0]      padOeB,
  output logic [W-1:0]      padOeE,
  output logic [W-1:0]      padOeK,
  output logic [W-1:0]      pullCfg,
  output logic [W-1:0]      driveCfg,
  output logic              visOn
);

  localparam int VIS_BIT = 3;
  localparam int RW_BIT  = 2;
  localparam int AS_BIT  = 3;

  logic [W-1:0]   regFile [NREG];
  logic [2*W-1:0] addrQ;
  logic [2*W-1:0] wdataQ;
  logic [W-1:0]   rdMux;
  logic           busOn;
  logic           inCycle;

  for (genvar g = 0; g < NREG; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regFile[g] <= '0;
      else if (stb.wrSel[g]) regFile[g] <= regWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      busRdata <= '0;
      busDone  <= 1'b0;
    end else begin
      if (stb.busStart) begin
        addrQ  <= busAddr;
        wdataQ <= busWdata;
      end
      if (!stb.hold) begin
        busDone <= stb.dataPh;
        if (stb.dataPh)
          busRdata <= stb.wideBus ? {padInA, padInB} : {{W{1'b0}}, padInA};
      end
    end
  end

  function automatic logic [W-1:0] mixIn(input logic [W-1:0] d, input logic [W-1:0] dir,
                                         input logic [W-1:0] pin);
    return (dir & d) | (~dir & pin);
  endfunction

  always_comb begin
    case (stb.rdSel)
      R_PA:    rdMux = mixIn(regFile[R_PA], regFile[R_DA], padInA);
      R_PB:    rdMux = mixIn(regFile[R_PB], regFile[R_DB], padInB);
      R_PE:    rdMux = mixIn(regFile[R_PE], regFile[R_DE], padInE);
      R_PK:    rdMux = mixIn(regFile[R_PK], regFile[R_DK], padInK);
      R_MODE:  begin
        rdMux = '0;
        rdMux[W-1 -: MODE_W] = modeNow;
        rdMux[VIS_BIT] = regFile[R_MODE][VIS_BIT];
      end
      R_NONE:  rdMux = '0;
      default: rdMux = regFile[stb.rdSel];
    endcase
  end

  assign regRdata = stb.rdEn ? rdMux : '0;
  assign pullCfg  = regFile[R_PULL];
  assign driveCfg = regFile[R_DRV];
  assign visOn    = regFile[R_MODE][VIS_BIT] && stb.visAllowed;
  assign busOn    = stb.wideBus || stb.narrowBus;
  assign inCycle  = stb.addrPh || stb.dataPh;

  always_comb begin
    padOutA = regFile[R_PA];  padOeA = regFile[R_DA];
    padOutB = regFile[R_PB];  padOeB = regFile[R_DB];
    padOutE = regFile[R_PE];  padOeE = regFile[R_DE];
    padOutK = regFile[R_PK];  padOeK = regFile[R_DK];
    if (busOn) begin
      padOutA = '0; padOeA = '0;
      padOutB = '0; padOeB = '0;
      if (stb.addrPh) begin
        padOutA = addrQ[2*W-1:W]; padOeA = '1;
        padOutB = addrQ[W-1:0];   padOeB = '1;
      end else if (stb.dataPh) begin
        if (stb.wideBus) begin
          padOutA = wdataQ[2*W-1:W];
          padOutB = wdataQ[W-1:0];
          padOeA  = {W{stb.isWrite}};
          padOeB  = {W{stb.isWrite}};
        end else begin
          padOutA = wdataQ[W-1:0];
          padOeA  = {W{stb.isWrite}};
          padOutB = addrQ[W-1:0];
          padOeB  = '1;
        end
      end
      padOutE[RW_BIT] = !(inCycle && stb.isWrite);
      padOeE[RW_BIT]  = 1'b1;
      padOutE[AS_BIT] = stb.addrPh;
      padOeE[AS_BIT]  = 1'b1;
    end
  end

endmodule

// File: rtl/xbus_top.sv
module xbus_top
  import xbus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stop,
  input  logic [2:0]  modePins,
  input  logic [5:0]  regAddr,
  input  logic [7:0]  regWdata,
  input  logic        regWe,
  input  logic        regRe,
  output logic [7:0]  regRdata,
  input  logic        busReq,
  input  logic        busWrite,
  input  logic [15:0] busAddr,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  output logic        busDone,
  output logic        busAddrPhase,
  output logic        busDataPhase,
  input  logic [7:0]  padInA,
  input  logic [7:0]  padInB,
  input  logic [7:0]  padInE,
  input  logic [7:0]  padInK,
  output logic [7:0]  padOutA,
  output logic [7:0]  padOutB,
  output logic [7:0]  padOutE,
  output logic [7:0]  padOutK,
  output logic [7:0]  padOeA,
  output logic [7:0]  padOeB,
  output logic [7:0]  padOeE,
  output logic [7:0]  padOeK,
  output logic [7:0]  pullCfg,
  output logic [7:0]  driveCfg,
  output logic        visOn
);

  strobe_t     stb;
  logic [2:0]  modeNow;
  logic        curWrite;

  xbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stop(stop), .modePins(modePins),
    .regAddr(regAddr), .regWe(regWe), .regRe(regRe),
    .busReq(busReq), .busWrite(busWrite),
    .modeNow(modeNow), .stb(stb)
  );

  xbus_dpath #(.W(PORT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .modeNow(modeNow),
    .regWdata(regWdata), .busAddr(busAddr), .busWdata(busWdata),
    .padInA(padInA), .padInB(padInB), .padInE(padInE), .padInK(padInK),
    .regRdata(regRdata), .busRdata(busRdata), .busDone(busDone),
    .padOutA(padOutA), .padOutB(padOutB), .padOutE(padOutE), .padOutK(padOutK),
    .padOeA(padOeA), .padOeB(padOeB), .padOeE(padOeE), .padOeK(padOeK),
    .pullCfg(pullCfg), .driveCfg(driveCfg), .visOn(visOn)
  );

  assign busAddrPhase = stb.addrPh;
  assign busDataPhase = stb.dataPh;
  assign curWrite     = stb.isWrite;

endmodule

// File: rtl/xbus_chk.sv
module xbus_chk (
  input logic       clk,
  input logic       rstN,
  input logic       stop,
  input logic       regRe,
  input logic [5:0] regAddr,
  input logic [7:0] regRdata,
  input logic [2:0] modeNow,
  input logic       busAddrPhase,
  input logic       busDataPhase,
  input logic       curWrite,
  input logic [7:0] padOeA,
  input logic [7:0] padOeB,
  input logic       visOn
);

  logic wideMode;
  logic reservedHit;
  assign wideMode    = (modeNow == 3'b011) || (modeNow == 3'b111) || (modeNow == 3'b010);
  assign reservedHit = (regAddr inside {6'h04, 6'h05, 6'h06, 6'h07, 6'h0F});

  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(modeNow));

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && reservedHit) |-> (regRdata == 8'h00));

  p_addr_drive_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busAddrPhase && wideMode) |-> (padOeA == 8'hFF && padOeB == 8'hFF));

  p_read_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busDataPhase && !curWrite && wideMode) |-> (padOeA == 8'h00 && padOeB == 8'h00));

  p_phase_order_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busAddrPhase && !stop) |=> busDataPhase);

  p_phase_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busAddrPhase, busDataPhase}));

  p_vis_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    visOn |-> (wideMode || modeNow == 3'b001));

  p_stop_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    stop |=> $stable({busAddrPhase, busDataPhase}));

  p_stop_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    stop |-> (regRdata == 8'h00));

endmodule

bind xbus_top xbus_chk u_chk (
  .clk(clk), .rstN(rstN), .stop(stop), .regRe(regRe), .regAddr(regAddr),
  .regRdata(regRdata), .modeNow(modeNow), .busAddrPhase(busAddrPhase),
  .busDataPhase(busDataPhase), .curWrite(curWrite), .padOeA(padOeA),
  .padOeB(padOeB), .visOn(visOn)
);

// File: tb/xbus_top_tb.sv
`timescale 1ns/1ps
module xbus_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stop = 1'b0;
  logic [2:0]  modePins = 3'b100;
  logic [5:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic        regWe = 1'b0;
  logic        regRe = 1'b0;
  logic [7:0]  regRdata;
  logic        busReq = 1'b0;
  logic        busWrite = 1'b0;
  logic [15:0] busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        busDone, busAddrPhase, busDataPhase;
  logic [7:0]  padInA = '0, padInB = '0, padInE = '0, padInK = '0;
  logic [7:0]  padOutA, padOutB, padOutE, padOutK;
  logic [7:0]  padOeA, padOeB, padOeE, padOeK;
  logic [7:0]  pullCfg, driveCfg;
  logic        visOn;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  xbus_top u_dut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a; regRe = 1'b1;
    #1 v = regRdata;
    regRe = 1'b0;
  endtask

  task automatic doReset(input logic [2:0] m);
    @(negedge clk);
    rstN = 1'b0; modePins = m;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modePins = ~m;
  endtask

  // R1 and R2: reset values and latched mode
  task automatic tReset();
    logic [7:0] v;
    logic [5:0] offs [13] = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h08, 6'h09, 6'h0A,
                              6'h0C, 6'h0D, 6'h0E, 6'h1E, 6'h32, 6'h33};
    doReset(3'b100);
    repeat (2) @(negedge clk);
    rd(6'h0B, v); chk("R1", "mode readback 100", v, 8'h80);
    foreach (offs[i]) begin
      rd(offs[i], v); chk("R2", $sformatf("reset value @%h", offs[i]), v, 8'h00);
    end
    chk("R4", "all oe off after reset", {padOeA, padOeB, padOeE, padOeK}, 32'h0);
  endtask

  // R2: readback of every writable register
  task automatic tRegMap();
    logic [7:0] v;
    doReset(3'b100);
    wr(6'h02, 8'hFF); wr(6'h03, 8'hFF); wr(6'h09, 8'hFF); wr(6'h33, 8'hFF);
    wr(6'h00, 8'h11); wr(6'h01, 8'h22); wr(6'h08, 8'h33); wr(6'h32, 8'h44);
    wr(6'h0A, 8'h55); wr(6'h0C, 8'h66); wr(6'h0D, 8'h77); wr(6'h0E, 8'h88);
    wr(6'h1E, 8'h99);
    rd(6'h00, v); chk("R2", "A data", v, 8'h11);
    rd(6'h01, v); chk("R2", "B data", v, 8'h22);
    rd(6'h08, v); chk("R2", "E data", v, 8'h33);
    rd(6'h32, v); chk("R2", "K data", v, 8'h44);
    rd(6'h02, v); chk("R2", "A dir", v, 8'hFF);
    rd(6'h0A, v); chk("R2", "E assign", v, 8'h55);
    rd(6'h0E, v); chk("R2", "bus ctl", v, 8'h88);
    rd(6'h1E, v); chk("R2", "irq ctl", v, 8'h99);
    chk("R2", "pullCfg", pullCfg, 8'h66);
    chk("R2", "driveCfg", driveCfg, 8'h77);
  endtask

  // R3: reserved offsets
  task automatic tReserved();
    logic [7:0] v;
    logic [5:0] res [6] = '{6'h04, 6'h05, 6'h06, 6'h07, 6'h0F, 6'h20};
    doReset(3'b100);
    wr(6'h02, 8'hFF); wr(6'h00, 8'h3C); wr(6'h0C, 8'hA1);
    foreach (res[i]) begin
      wr(res[i], 8'h5A);
      rd(res[i], v); chk("R3", $sformatf("reserved @%h", res[i]), v, 8'h00);
    end
    rd(6'h00, v); chk("R3", "A data untouched", v, 8'h3C);
    chk("R3", "pullCfg untouched", pullCfg, 8'hA1);
  endtask

  // R4: GPIO muxing
  task automatic tGpio();
    logic [7:0] v;
    doReset(3'b100);
    wr(6'h02, 8'h0F); wr(6'h00, 8'hA5);
    wr(6'h09, 8'hF0); wr(6'h08, 8'h5A);
    @(negedge clk); padInA = 8'h3C;
    #1;
    chk("R4", "A out", padOutA, 8'hA5);
    chk("R4", "A oe", padOeA, 8'h0F);
    chk("R4", "E oe single-chip", padOeE, 8'hF0);
    rd(6'h00, v); chk("R4", "A read mix", v, 8'h35);
    padInA = 8'h00;
  endtask

  task automatic busCycle(input logic wrt, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    busReq = 1'b1; busWrite = wrt; busAddr = a; busWdata = d;
    @(negedge clk);
    busReq = 1'b0; busAddr = '0; busWdata = '0;
  endtask

  // R5, R7, R4(K): wide mode cycles
  task automatic tWide();
    doReset(3'b111);
    wr(6'h33, 8'hFF); wr(6'h32, 8'h77);
    #1;
    chk("R4", "K out wide", padOutK, 8'h77);
    chk("R4", "K oe wide", padOeK, 8'hFF);
    chk("R5", "idle A/B released", {padOeA, padOeB}, 16'h0);
    chk("R7", "E rw high idle", {padOutE[2], padOeE[2]}, 2'b11);
    busCycle(1'b1, 16'h1234, 16'hBEEF);
    #1;
    chk("R5", "addr phase flag", busAddrPhase, 1'b1);
    chk("R5", "addr on A/B", {padOutA, padOutB}, 16'h1234);
    chk("R5", "addr oe", {padOeA, padOeB}, 16'hFFFF);
    chk("R7", "strobe in addr", padOutE[3], 1'b1);
    chk("R7", "rw low on write", padOutE[2], 1'b0);
    @(negedge clk); #1;
    chk("R5", "data phase flag", busDataPhase, 1'b1);
    chk("R5", "write data on A/B", {padOutA, padOutB}, 16'hBEEF);
    chk("R5", "write oe", {padOeA, padOeB}, 16'hFFFF);
    chk("R7", "strobe off in data", padOutE[3], 1'b0);
    @(negedge clk); #1;
    chk("R5", "done after write", busDone, 1'b1);
    padInA = 8'hCA; padInB = 8'hFE;
    busCycle(1'b0, 16'h0F0F, 16'h0);
    @(negedge clk); #1;
    chk("R5", "read releases A/B", {padOeA, padOeB}, 16'h0);
    chk("R7", "rw high on read", padOutE[2], 1'b1);
    @(negedge clk); #1;
    chk("R5", "read done", busDone, 1'b1);
    chk("R5", "read data", busRdata, 16'hCAFE);
    padInA = '0; padInB = '0;
  endtask

  // R6: narrow mode
  task automatic tNarrow();
    doReset(3'b101);
    busCycle(1'b1, 16'hA1B2, 16'h00C3);
    #1;
    chk("R6", "narrow addr", {padOutA, padOutB}, 16'hA1B2);
    @(negedge clk); #1;
    chk("R6", "narrow data on A", padOutA, 8'hC3);
    chk("R6", "narrow A oe", padOeA, 8'hFF);
    chk("R6", "narrow B holds addr", {padOutB, padOeB}, 16'hB2FF);
    padInA = 8'h5D; padInB = 8'h99;
    busCycle(1'b0, 16'h4455, 16'h0);
    @(negedge clk); #1;
    chk("R6", "narrow read A released", padOeA, 8'h00);
    chk("R6", "narrow read B addr", {padOutB, padOeB}, 16'h55FF);
    @(negedge clk); #1;
    chk("R6", "narrow read data", busRdata, 16'h005D);
    padInA = '0; padInB = '0;
  endtask

  // R9: write-once protection
  task automatic tProtect();
    logic [7:0] v;
    doReset(3'b100);
    wr(6'h0E, 8'h01); wr(6'h0E, 8'h02);
    rd(6'h0E, v); chk("R9", "normal bctl first write kept", v, 8'h01);
    wr(6'h0B, 8'h08); wr(6'h0B, 8'h00);
    rd(6'h0B, v); chk("R9", "normal mode bit locked", v, 8'h88);
    doReset(3'b010);
    wr(6'h0E, 8'h01); wr(6'h0E, 8'h02);
    rd(6'h0E, v); chk("R9", "special bctl rewritable", v, 8'h02);
    wr(6'h0B, 8'h08); wr(6'h0B, 8'h00);
    rd(6'h0B, v); chk("R9", "special mode bit rewritable", v, 8'h40);
  endtask

  // R8: visibility gating
  task automatic tVis();
    logic [2:0] ms [4] = '{3'b101, 3'b001, 3'b111, 3'b100};
    logic       ex [4] = '{1'b0, 1'b1, 1'b1, 1'b0};
    foreach (ms[i]) begin
      doReset(ms[i]);
      wr(6'h0B, 8'h08);
      #1 chk("R8", $sformatf("visOn mode %b", ms[i]), visOn, ex[i]);
    end
  endtask

  // R10: stop freezes
  task automatic tStop();
    logic [7:0] v;
    doReset(3'b111);
    wr(6'h02, 8'hFF); wr(6'h00, 8'h11);
    @(negedge clk); stop = 1'b1;
    wr(6'h00, 8'h99);
    rd(6'h00, v); chk("R10", "read zero in stop", v, 8'h00);
    @(negedge clk); stop = 1'b0;
    rd(6'h00, v); chk("R10", "write dropped in stop", v, 8'h11);
    busCycle(1'b1, 16'h2222, 16'h3333);
    stop = 1'b1;
    @(negedge clk); #1;
    chk("R10", "addr phase frozen", {busAddrPhase, busDataPhase}, 2'b10);
    stop = 1'b0;
    @(negedge clk); #1;
    chk("R10", "advance after stop", {busAddrPhase, busDataPhase}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    tReset();
    tRegMap();
    tReserved();
    tGpio();
    tWide();
    tNarrow();
    tProtect();
    tVis();
    tStop();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule